// File: doc/BRIEF.md
# Register-Style TPM Target over SPI

This block is the target side of a SPI link that carries register-style TPM accesses with in-band flow control. The host opens a transaction by pulling chip select low and sending a header byte that states the direction (read or write) and how many data bytes will move. It then sends a 3-byte address. While the header and address shift in, the target answers with zero bytes. After the address, the host keeps clocking single bytes and watches bit 0 of each reply. A zero reply means the target is still waiting for its back end. The first reply with bit 0 set (0x01) releases the host, and the stated number of data bytes follows on the single data lane.

On the back-end side the block issues register accesses through a valid/ready style handshake. A read transaction fetches its first byte before it releases the host, so the first data byte shifts out with no gap. Each later byte is fetched one byte ahead. A write transaction releases the host once the back end signals that it can accept. Each received byte is then presented as one write at an incrementing address. A wait limit stops endless polling: once it is reached, the block raises a timeout flag and stops answering with the start code. Chip select high aborts any transaction at any stage.

The serial pins are sampled in the system clock domain, so the SPI clock must run well below the system clock. SPI mode 0 is used: data in is captured on the rising SPI clock edge, and data out changes after the falling edge, most significant bit first.

Top module: `tpm_tgt`

## Requirements
- R1: After reset, and on every cycle where chip select has been high for two samples, `spi_miso`, `be_req` and (after reset) `timeout` are 0.
- R2: The target returns 0x00 on `spi_miso` during the header byte and during each of the three address bytes.
- R3: The polled replies after the address are 0x00 until the target is ready, then exactly one 0x01, then data. The first polled reply is always 0x00. If the back end becomes ready while poll byte m (0-based) is being clocked, poll byte m+1 carries 0x01.
- R4: For a read, `be_req` rises with `be_write`=0 and `be_addr` equal to the received address once the third address byte completes. Data byte k returned after the 0x01 reply is the back-end value at address base+k, sent MSB first.
- R5: The header is decoded as follows: bit 7 = 1 means read and 0 means write, bits 5:0 hold the size minus 1 (1 to 64 bytes), and bit 6 is ignored. Exactly that many data bytes move and exactly that many back-end accesses are made. Any byte clocked after the last data byte returns 0xFF.
- R6: For a write, `spi_miso` returns 0x00 during the data bytes. Each complete received byte k is presented once with `be_write`=1, `be_addr`=base+k and `be_wdata`=the byte. `be_req` and `be_addr` hold until `be_ready` is seen.
- R7: A write transaction's 0x01 reply is released by `be_ready` being high during the polling phase.
- R8: With parameter MAX_WAIT = N, if the back end is not ready when the N-th 0x00 poll reply completes, `timeout` rises. At that point `be_req` drops and all further replies are 0x00. `timeout` stays high until chip select falls again.
- R9: Chip select high aborts the transaction at any point. A pending request drops, a partly received write byte is not written, and the next transaction starts again with a header.
- R10: SPI mode 0 is used: `spi_mosi` is captured on the rising edge of `spi_sck`, and `spi_miso` presents the next bit after each falling edge. The first bit of every reply is already valid before that byte's first rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, also used to oversample the SPI pins |
| rst_n | input | 1 | Synchronous active-low reset |
| spi_sck | input | 1 | SPI clock from the host, idle low |
| spi_csn | input | 1 | Chip select, active low |
| spi_mosi | input | 1 | Serial data from the host |
| spi_miso | output | 1 | Serial data to the host |
| be_req | output | 1 | Back-end access request, held until accepted |
| be_write | output | 1 | 1 for a write access, 0 for a read |
| be_addr | output | ADDR_W | Access address (base plus byte index) |
| be_wdata | output | 8 | Write data byte |
| be_rdata | input | 8 | Read data, taken in the cycle `be_ready` accepts a read |
| be_ready | input | 1 | Back end accepts the request / can accept writes |
| timeout | output | 1 | Wait limit reached in this transaction |

## Verification
Almost every internal slip shows up on the serial reply stream within one byte time. A wrong phase or byte counter moves the 0x01 reply or the trailing 0xFF by a whole byte. A stale hold register returns the wrong data byte. A lost shift or a shift on the wrong edge garbles the reply bits. Slips on the back-end side show up sooner, on the next clock, as a request that drops before acceptance, a drifting address, or one access too many or too few per transaction. The timeout counter is observed through the exact poll count at which `timeout` rises, and through its clearing only at the next chip-select fall.

// File: rtl/tpm_tgt_pkg.sv
// Shared phase encoding and reply codes for the SPI TPM target.
package tpm_tgt_pkg;

    // Transaction phases, in the order a transaction passes through them.
    typedef enum logic [2:0] {
        PH_HDR  = 3'd0,
        PH_ADDR = 3'd1,
        PH_POLL = 3'd2,
        PH_GO   = 3'd3,
        PH_DATA = 3'd4,
        PH_DONE = 3'd5,
        PH_HALT = 3'd6
    } phase_e;

    localparam logic [7:0] RSP_WAIT  = 8'h00;
    localparam logic [7:0] RSP_START = 8'h01;
    localparam logic [7:0] RSP_FILL  = 8'hFF;

    localparam int HDR_DIR_BIT = 7;   // 1 = read
    localparam int SIZE_W      = 6;   // header size field, holds size-1

endpackage

// File: rtl/tpm_tgt_shift.sv
// Serial byte engine for SPI mode 0.
// Oversamples SCK in the clk domain (SCK must be much slower than clk and
// free of glitches; the pins are assumed already synchronised).
// Receives MSB first on SCK rising edges and reports each complete byte.
// Transmits MSB first, advancing after falling edges. A new reply byte is
// loaded when the previous byte completes, so its first bit is valid before
// the next rising edge. Chip select high clears all serial state.
module tpm_tgt_shift (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sck,
    input  logic       csn,
    input  logic       mosi,
    input  logic       load,
    input  logic [7:0] load_byte,
    output logic       miso,
    output logic       byte_done,
    output logic [7:0] rx_byte
);

    logic       sck_q;
    logic [2:0] bit_cnt;
    logic [6:0] rx_sr;
    logic [7:0] tx_sr;
    logic       sck_rise;
    logic       sck_fall;

    // Edge detection on the oversampled SPI clock, only while selected.
    assign sck_rise = sck && !sck_q && !csn;
    assign sck_fall = !sck && sck_q && !csn;

    // A byte completes on the eighth rising edge; the last bit comes straight from the pin.
    assign byte_done = sck_rise && (bit_cnt == 3'd7);
    assign rx_byte   = {rx_sr, mosi};
    assign miso      = tx_sr[7];

    // Track the previous SCK level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sck_q <= 1'b0;
        end else begin
            sck_q <= sck;
        end
    end

    // Receive shift register and bit counter.
    always_ff @(posedge clk) begin
        if (!rst_n || csn) begin
            bit_cnt <= 3'd0;
            rx_sr   <= '0;
        end else if (sck_rise) begin
            bit_cnt <= bit_cnt + 3'd1;
            rx_sr   <= {rx_sr[5:0], mosi};
        end
    end

    // Transmit register: load at byte boundaries, shift after falls inside a byte.
    always_ff @(posedge clk) begin
        if (!rst_n || csn) begin
            tx_sr <= 8'h00;
        end else if (load) begin
            tx_sr <= load_byte;
        end else if (sck_fall && (bit_cnt != 3'd0)) begin
            tx_sr <= {tx_sr[6:0], 1'b0};
        end
    end

endmodule

// File: rtl/tpm_tgt_ctrl.sv
// Transaction sequencer for the SPI TPM target.
// Walks through header, address, polling, start, data and trailing phases
// on each completed byte, and chooses the next reply byte. Drives the
// back-end request with a valid/ready handshake. Assumes each back-end
// access completes within one byte time once the data phase has begun.
module tpm_tgt_ctrl
    import tpm_tgt_pkg::*;
#(
    parameter int ADDR_BYTES = 3,
    parameter int MAX_WAIT   = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    csn,
    input  logic                    byte_done,
    input  logic [7:0]              rx_byte,
    output logic [7:0]              next_reply,
    output logic                    be_req,
    output logic                    be_write,
    output logic [8*ADDR_BYTES-1:0] be_addr,
    output logic [7:0]              be_wdata,
    input  logic [7:0]              be_rdata,
    input  logic                    be_ready,
    output logic                    timeout
);

    localparam int ADDR_W = 8 * ADDR_BYTES;
    localparam int WCNT_W = $clog2(MAX_WAIT + 1);
    localparam int ACNT_W = $clog2(ADDR_BYTES) + 1;

    phase_e              phase;
    logic [ACNT_W-1:0]   addr_cnt;
    logic [ADDR_W-1:0]   base_addr;
    logic                is_read;
    logic [SIZE_W-1:0]   size_m1;
    logic [SIZE_W-1:0]   data_idx;
    logic [SIZE_W-1:0]   req_idx;
    logic [WCNT_W-1:0]   wait_cnt;
    logic                ready_seen;
    logic                req_q;
    logic [7:0]          hold_q;
    logic [7:0]          wdata_q;
    logic                timeout_q;
    logic                csn_q;
    logic                last_data;
    logic                more_fetch;

    assign last_data  = (data_idx == size_m1);
    assign more_fetch = ({1'b0, data_idx} + (SIZE_W+1)'(2)) <= {1'b0, size_m1};

    assign be_req   = req_q;
    assign be_write = !is_read;
    assign be_addr  = base_addr + ADDR_W'(req_idx);
    assign be_wdata = wdata_q;
    assign timeout  = timeout_q;

    // Reply byte to load when the current byte completes.
    always_comb begin
        unique case (phase)
            PH_POLL: next_reply = ready_seen ? RSP_START : RSP_WAIT;
            PH_GO:   next_reply = is_read ? hold_q : RSP_WAIT;
            PH_DATA: next_reply = last_data ? RSP_FILL : (is_read ? hold_q : RSP_WAIT);
            PH_DONE: next_reply = RSP_FILL;
            default: next_reply = RSP_WAIT;
        endcase
    end

    // Timeout flag: set on wait overflow, cleared when chip select falls.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            timeout_q <= 1'b0;
            csn_q     <= 1'b1;
        end else begin
            csn_q <= csn;
            if (csn_q && !csn) begin
                timeout_q <= 1'b0;
            end else if (!csn && byte_done && phase == PH_POLL && !ready_seen
                         && wait_cnt == WCNT_W'(MAX_WAIT)) begin
                timeout_q <= 1'b1;
            end
        end
    end

    // Phase sequencing, counters and back-end handshake.
    always_ff @(posedge clk) begin
        if (!rst_n || csn) begin
            phase      <= PH_HDR;
            addr_cnt   <= '0;
            base_addr  <= '0;
            is_read    <= 1'b0;
            size_m1    <= '0;
            data_idx   <= '0;
            req_idx    <= '0;
            wait_cnt   <= '0;
            ready_seen <= 1'b0;
            req_q      <= 1'b0;
            hold_q     <= 8'h00;
            wdata_q    <= 8'h00;
        end else begin
            if (req_q && be_ready) begin
                req_q <= 1'b0;
                if (is_read) begin
                    hold_q     <= be_rdata;
                    ready_seen <= 1'b1;
                end
            end
            if (phase == PH_POLL && !is_read && be_ready) begin
                ready_seen <= 1'b1;
            end
            if (byte_done) begin
                unique case (phase)
                    PH_HDR: begin
                        is_read  <= rx_byte[HDR_DIR_BIT];
                        size_m1  <= rx_byte[SIZE_W-1:0];
                        addr_cnt <= '0;
                        phase    <= PH_ADDR;
                    end
                    PH_ADDR: begin
                        base_addr <= (base_addr << 8) | ADDR_W'(rx_byte);
                        addr_cnt  <= addr_cnt + ACNT_W'(1);
                        if (addr_cnt == ACNT_W'(ADDR_BYTES - 1)) begin
                            phase    <= PH_POLL;
                            wait_cnt <= WCNT_W'(1);
                            if (is_read) begin
                                req_q   <= 1'b1;
                                req_idx <= '0;
                            end
                        end
                    end
                    PH_POLL: begin
                        if (ready_seen) begin
                            phase <= PH_GO;
                        end else if (wait_cnt == WCNT_W'(MAX_WAIT)) begin
                            phase <= PH_HALT;
                            req_q <= 1'b0;
                        end else begin
                            wait_cnt <= wait_cnt + WCNT_W'(1);
                        end
                    end
                    PH_GO: begin
                        phase    <= PH_DATA;
                        data_idx <= '0;
                        if (is_read && size_m1 != '0) begin
                            req_q   <= 1'b1;
                            req_idx <= SIZE_W'(1);
                        end
                    end
                    PH_DATA: begin
                        data_idx <= data_idx + SIZE_W'(1);
                        if (!is_read) begin
                            req_q   <= 1'b1;
                            req_idx <= data_idx;
                            wdata_q <= rx_byte;
                        end else if (more_fetch) begin
                            req_q   <= 1'b1;
                            req_idx <= data_idx + SIZE_W'(2);
                        end
                        if (last_data) begin
                            phase <= PH_DONE;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

endmodule

// File: rtl/tpm_tgt.sv
// SPI TPM transaction target, top level.
// Joins the serial byte engine and the transaction sequencer; every
// completed byte loads the reply chosen by the sequencer.
module tpm_tgt #(
    parameter int ADDR_BYTES = 3,
    parameter int MAX_WAIT   = 16,
    parameter int ADDR_W     = 8 * ADDR_BYTES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              spi_sck,
    input  logic              spi_csn,
    input  logic              spi_mosi,
    output logic              spi_miso,
    output logic              be_req,
    output logic              be_write,
    output logic [ADDR_W-1:0] be_addr,
    output logic [7:0]        be_wdata,
    input  logic [7:0]        be_rdata,
    input  logic              be_ready,
    output logic              timeout
);

    logic       byte_done;
    logic [7:0] rx_byte;
    logic [7:0] next_reply;

    tpm_tgt_shift u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .sck       (spi_sck),
        .csn       (spi_csn),
        .mosi      (spi_mosi),
        .load      (byte_done),
        .load_byte (next_reply),
        .miso      (spi_miso),
        .byte_done (byte_done),
        .rx_byte   (rx_byte)
    );

    tpm_tgt_ctrl #(
        .ADDR_BYTES (ADDR_BYTES),
        .MAX_WAIT   (MAX_WAIT)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .csn        (spi_csn),
        .byte_done  (byte_done),
        .rx_byte    (rx_byte),
        .next_reply (next_reply),
        .be_req     (be_req),
        .be_write   (be_write),
        .be_addr    (be_addr),
        .be_wdata   (be_wdata),
        .be_rdata   (be_rdata),
        .be_ready   (be_ready),
        .timeout    (timeout)
    );

endmodule

// File: rtl/tpm_tgt_chk.sv
// Port-level protocol checks for tpm_tgt, attached with bind.
module tpm_tgt_chk #(
    parameter int ADDR_W = 24
) (
    input logic              clk,
    input logic              rst_n,
    input logic              spi_csn,
    input logic              spi_miso,
    input logic              be_req,
    input logic [ADDR_W-1:0] be_addr,
    input logic              be_ready,
    input logic              timeout
);

    // R1: deselected target is silent and makes no requests.
    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (spi_csn && $past(spi_csn)) |-> (!be_req && !spi_miso));

    // R6: a request is held until accepted (abort or timeout excepted).
    a_r6_req_held: assert property (@(posedge clk) disable iff (!rst_n)
        (be_req && !be_ready && !spi_csn) |=> (be_req || spi_csn || timeout));

    // R6: the address of a waiting request does not move.
    a_r6_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (be_req && !be_ready && !spi_csn) |=> ($stable(be_addr) || spi_csn || !be_req));

    // R8: no back-end traffic once the wait limit has expired.
    a_r8_timeout_no_req: assert property (@(posedge clk) disable iff (!rst_n)
        timeout |-> !be_req);

    // R8: the flag only clears on a falling chip select.
    a_r8_timeout_clear: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(timeout) |-> ($past(spi_csn, 2) && !$past(spi_csn)));

endmodule

bind tpm_tgt tpm_tgt_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .spi_csn  (spi_csn),
    .spi_miso (spi_miso),
    .be_req   (be_req),
    .be_addr  (be_addr),
    .be_ready (be_ready),
    .timeout  (timeout)
);

// File: tb/tpm_tgt_tb.sv
// Self-checking bench: behavioural host, back-end memory and per-clock monitor.
module tpm_tgt_tb;

    localparam int MAXW = 4;
    localparam int HALF = 4;   // clk cycles per SCK half period

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        spi_sck = 1'b0;
    logic        spi_csn = 1'b1;
    logic        spi_mosi = 1'b0;
    logic        spi_miso;
    logic        be_req;
    logic        be_write;
    logic [23:0] be_addr;
    logic [7:0]  be_wdata;
    logic [7:0]  be_rdata = 8'h00;
    logic        be_ready = 1'b0;
    logic        timeout;

    int errors = 0;
    int checks = 0;
    bit go = 1'b0;
    int acc_cnt = 0;
    logic [7:0]  mem [256];
    logic [31:0] wlog [$];

    always #2.5 clk = ~clk;

    tpm_tgt #(.MAX_WAIT(MAXW)) u_dut (
        .clk(clk), .rst_n(rst_n), .spi_sck(spi_sck), .spi_csn(spi_csn),
        .spi_mosi(spi_mosi), .spi_miso(spi_miso), .be_req(be_req),
        .be_write(be_write), .be_addr(be_addr), .be_wdata(be_wdata),
        .be_rdata(be_rdata), .be_ready(be_ready), .timeout(timeout)
    );

    task automatic check(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h at %0t", what, act, exp, $time);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) begin
            @(posedge clk);
            #1;
        end
    endtask

    // Back-end model: ready follows go, read data follows the address.
    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 8'(i * 7 + 3);
        forever begin
            @(posedge clk);
            #2;
            be_ready = go;
            be_rdata = mem[be_addr[7:0]];
        end
    end

    // Per-clock monitor: idle silence, held requests, accepted accesses.
    logic        p_csn = 1'b1;
    logic        p_req = 1'b0;
    logic        p_rdy = 1'b0;
    logic [23:0] p_addr = '0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (spi_csn && p_csn)
                check(!be_req && !spi_miso, "R1 idle outputs", {be_req, spi_miso}, 0);
            if (p_req && !p_rdy && !p_csn)
                check((be_req && be_addr == p_addr) || timeout, "R6 request held",
                      be_addr, p_addr);
            if (!spi_csn && be_req && be_ready) begin
                acc_cnt++;
                if (be_write) begin
                    mem[be_addr[7:0]] = be_wdata;
                    wlog.push_back({be_addr, be_wdata});
                end
            end
        end
        p_csn  = spi_csn;
        p_req  = be_req;
        p_rdy  = be_ready;
        p_addr = be_addr;
    end

    task automatic cs_low();
        spi_csn = 1'b0;
        tick(HALF);
    endtask

    task automatic cs_high();
        tick(HALF);
        spi_csn = 1'b1;
        tick(2 * HALF);
    endtask

    task automatic xbits(input logic [7:0] tx, input int n, output logic [7:0] rx);
        rx = 8'h00;
        for (int i = 7; i > 7 - n; i--) begin
            spi_mosi = tx[i];
            tick(HALF);
            rx[i] = spi_miso;
            spi_sck = 1'b1;
            tick(HALF);
            spi_sck = 1'b0;
        end
    endtask

    task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
        xbits(tx, 8, rx);
    endtask

    // Header and address; every reply must be 0x00 (R2).
    task automatic send_head(input bit rd, input int size, input logic [23:0] base);
        logic [7:0] r;
        xfer({rd, 1'b1, 6'(size - 1)}, r);
        check(r == 8'h00, "R2 header reply", r, 0);
        for (int a = 0; a < 3; a++) begin
            xfer(base[23 - 8*a -: 8], r);
            check(r == 8'h00, "R2 address reply", r, 0);
        end
    endtask

    // Poll until the start code; go is raised before poll byte m.
    task automatic poll(input int m);
        logic [7:0] r;
        int zeros = 0;
        bit got = 1'b0;
        for (int j = 0; j < 20 && !got; j++) begin
            if (j == m) go = 1'b1;
            xfer(8'h00, r);
            if (r == 8'h00) zeros++;
            else begin
                got = 1'b1;
                check(r == 8'h01, "R3 start code", r, 1);
            end
        end
        check(zeros == m + 1, "R3 wait byte count", zeros, m + 1);
    endtask

    task automatic do_read(input logic [23:0] base, input int size, input int m);
        logic [7:0] r;
        logic [7:0] e;
        acc_cnt = 0;
        cs_low();
        send_head(1'b1, size, base);
        check(be_req && !be_write && be_addr == base, "R4 first read request", be_addr, base);
        poll(m);
        for (int k = 0; k < size; k++) begin
            xfer(8'hA5, r);
            e = mem[8'(base[7:0] + k)];
            check(r == e, "R4 R10 read data", r, e);
        end
        xfer(8'h00, r);
        check(r == 8'hFF, "R5 trailing fill", r, 8'hFF);
        cs_high();
        go = 1'b0;
        check(acc_cnt == size, "R5 read access count", acc_cnt, size);
    endtask

    task automatic do_write(input logic [23:0] base, input int size, input int m, input int abort_at);
        logic [7:0] r;
        logic [7:0] d;
        int n;
        wlog.delete();
        cs_low();
        send_head(1'b0, size, base);
        check(!be_req, "R7 no write request before start", be_req, 0);
        poll(m);
        n = (abort_at < size) ? abort_at : size;
        for (int k = 0; k < n; k++) begin
            xfer(8'(k * 13 + 5), r);
            check(r == 8'h00, "R6 write phase reply", r, 0);
        end
        if (abort_at < size) begin
            xbits(8'hFF, 3, r);
        end else begin
            xfer(8'h00, r);
            check(r == 8'hFF, "R5 trailing fill", r, 8'hFF);
        end
        cs_high();
        go = 1'b0;
        check(wlog.size() == n, "R6 R9 write count", wlog.size(), n);
        for (int k = 0; k < n && k < wlog.size(); k++) begin
            d = 8'(k * 13 + 5);
            check(wlog[k] == {base + 24'(k), d}, "R6 R10 write access", wlog[k], {base + 24'(k), d});
        end
    endtask

    initial begin
        logic [7:0] r;
        tick(5);
        rst_n = 1'b1;
        tick(2);
        check(!spi_miso && !be_req && !timeout, "R1 reset state", {spi_miso, be_req, timeout}, 0);

        do_read(24'h12_3400, 4, 0);
        do_read(24'hAB_CD10, 1, 2);
        do_read(24'h00_0080, 64, MAXW - 1);

        do_write(24'h55_0020, 5, 1, 99);
        do_read(24'h55_0020, 5, 0);
        do_write(24'h00_0040, 1, 0, 99);

        // R9: abort inside the address, then a clean transaction.
        cs_low();
        xfer(8'h83, r);
        xfer(8'h00, r);
        xbits(8'hFF, 4, r);
        cs_high();
        check(!be_req && !timeout, "R9 abort in address", be_req, 0);
        do_read(24'h00_0010, 2, 1);

        // R9: abort with a read request pending.
        cs_low();
        send_head(1'b1, 3, 24'h00_0030);
        check(be_req, "R4 request pending", be_req, 1);
        cs_high();
        check(!be_req, "R9 pending request dropped", be_req, 0);

        // R9: abort in the middle of write data.
        do_write(24'h00_0060, 4, 0, 2);

        // R8: wait limit expiry.
        acc_cnt = 0;
        cs_low();
        send_head(1'b1, 2, 24'h00_0050);
        for (int j = 0; j < MAXW - 1; j++) begin
            xfer(8'h00, r);
            check(r == 8'h00, "R8 wait reply", r, 0);
        end
        check(!timeout, "R8 no timeout before limit", timeout, 0);
        xfer(8'h00, r);
        check(r == 8'h00 && timeout && !be_req, "R8 timeout raised", {r, timeout, be_req}, 2);
        go = 1'b1;
        for (int j = 0; j < 2; j++) begin
            xfer(8'h00, r);
            check(r == 8'h00, "R8 no start after timeout", r, 0);
        end
        check(acc_cnt == 0, "R8 no access after timeout", acc_cnt, 0);
        cs_high();
        go = 1'b0;
        check(timeout, "R8 flag held while deselected", timeout, 1);
        cs_low();
        tick(2);
        check(!timeout, "R8 flag cleared on select", timeout, 0);
        cs_high();

        do_read(24'h00_0060, 2, 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(150000 * 5);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule